// File: doc/BRIEF.md
# Data-Ready Triggered Burst Reader

This block is an SPI master that pulls a complete sensor sample set from a slave each time the slave signals that new data is ready. A rising edge on the data-ready input (resynchronised to the system clock) starts a transaction. The block lowers chip select, sends the 16-bit burst request word, and then clocks in a fixed number of 16-bit response words back to back. Each captured word appears on a parallel output together with its index and a one-cycle valid strobe.

The serial clock runs in mode 3: it idles high, outgoing bits change on falling edges and incoming bits are sampled on rising edges. Both directions are MSB first. Every half period of the serial clock lasts a parameter number of system clocks. An elaboration check rejects any setting whose resulting rate exceeds the 1 MHz burst ceiling. Consecutive words are separated by one extra serial clock period with the clock held high. A data-ready edge that arrives while a transaction is running does not restart it. Instead it bumps a saturating overrun counter.

Top module: `burst_reader`

## Requirements
- R1: While reset is high and on the first cycle after it, cs_n and sclk are 1, rd_valid and done are 0, and ovr_cnt is 0.
- R2: A 0-to-1 transition of data_ready while idle pulls cs_n low within 4 system clock cycles. A data_ready level held high starts only one transaction.
- R3: sclk stays high whenever cs_n is high. mosi changes only on a falling sclk edge or on the cycle cs_n falls. The slave drives miso after falling edges, and the block samples it on rising edges.
- R4: The first word sent on mosi in each transaction is 0x3E00, MSB first.
- R5: After the request word the block clocks in NWORDS response words, MSB first. Each is presented on rd_data with rd_idx counting 0 to NWORDS-1 in arrival order.
- R6: Each sclk high or low phase inside a word lasts HALF_DIV system clocks. Elaboration fails if SYS_FREQ_HZ/(2*HALF_DIV) exceeds 1 MHz.
- R7: cs_n falls while sclk is high, at least HALF_DIV cycles before the first falling sclk edge. cs_n rises at least HALF_DIV cycles after the last rising sclk edge.
- R8: Between the last rising edge of one word and the first falling edge of the next, exactly 3*HALF_DIV cycles pass. That is the normal half period plus one full extra period.
- R9: done is a one-cycle pulse raised in the same cycle cs_n returns high, after all NWORDS words have been presented.
- R10: A data_ready rising edge while a transaction is active increments ovr_cnt by one, saturating at its all-ones value, and neither restarts nor lengthens the transaction.
- R11: rd_valid is high for exactly one cycle per captured word and only while cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_ready | input | 1 | Slave data-ready line; a rising edge starts a transaction |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the slave |
| rd_valid | output | 1 | One-cycle strobe for a captured word |
| rd_data | output | 16 | Captured response word |
| rd_idx | output | IW | Index of the captured word, 0 first |
| done | output | 1 | One-cycle pulse when the transaction closes |
| ovr_cnt | output | OVR_W | Saturating count of data-ready edges seen while busy |

## Verification
The bench goes after word boundaries and transaction edges. A design that miscounts the inter-word gap, or drops the request word from the count, shows a wrong edge spacing or the wrong number of captured words. Data sets of all ones, all zeros and alternating end bits expose a bit-order or off-by-one shift error as a corrupted word. Overrun pulses injected at random points, repeated until the counter saturates, catch a design that restarts the transaction, wraps the counter or counts idle edges. A data-ready level held high past the end of a transaction catches level-triggered starts.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int WORD_W      = 16;
  localparam logic [WORD_W-1:0] BURST_CMD = 16'h3E00;
  localparam longint MAX_SCLK_HZ = 1_000_000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_GAP,
    ST_TAIL
  } rd_state_t;
endpackage

// File: rtl/burst_sync.sv
module burst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/burst_tick.sv
module burst_tick #(
  parameter int HALF_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)     cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = !clear && (cnt == LAST);
endmodule

// File: rtl/burst_shift.sv
module burst_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_out,
  input  logic         sample,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] cap_word
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)           tx_q <= load_val;
      else if (shift_out) tx_q <= {tx_q[W-2:0], 1'b0};
      if (sample)         rx_q <= {rx_q[W-2:0], miso};
    end
  end

  assign mosi     = tx_q[W-1];
  assign cap_word = {rx_q[W-2:0], miso};
endmodule

// File: rtl/burst_reader.sv
module burst_reader
  import burst_pkg::*;
#(
  parameter longint SYS_FREQ_HZ = 200_000_000,
  parameter int     HALF_DIV    = 100,
  parameter int     NWORDS      = 12,
  parameter int     OVR_W       = 8,
  parameter int     SYNC_STAGES = 2,
  parameter int     IW          = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_ready,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [IW-1:0]     rd_idx,
  output logic              done,
  output logic [OVR_W-1:0]  ovr_cnt
);
  localparam longint SCLK_HZ = SYS_FREQ_HZ / (2 * HALF_DIV);
  localparam int BW  = $clog2(WORD_W);
  localparam int WCW = $clog2(NWORDS + 1);
  localparam logic [BW-1:0]  LAST_BIT = BW'(WORD_W - 1);
  localparam logic [WCW-1:0] LAST_WRD = WCW'(NWORDS);

  if (HALF_DIV < 1) begin : g_div_err
    $error("HALF_DIV must be at least 1");
  end
  if (SCLK_HZ > MAX_SCLK_HZ) begin : g_rate_err
    $error("serial clock exceeds the burst-mode ceiling");
  end

  rd_state_t         state;
  logic [BW-1:0]     bitcnt;
  logic [WCW-1:0]    wcnt;
  logic              gcnt;
  logic              start_edge;
  logic              tick;
  logic              ld_tx;
  logic [WORD_W-1:0] ld_val;
  logic              sh_tx;
  logic              smp_rx;
  logic [WORD_W-1:0] cap_word;

  burst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (data_ready),
    .rise (start_edge)
  );

  burst_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (state == ST_IDLE),
    .tick  (tick)
  );

  always_comb begin
    ld_tx  = 1'b0;
    ld_val = '0;
    if (state == ST_IDLE && start_edge) begin
      ld_tx  = 1'b1;
      ld_val = BURST_CMD;
    end else if (state == ST_GAP && tick && gcnt) begin
      ld_tx  = 1'b1;
    end
    sh_tx  = (state == ST_XFER) && tick && sclk && (bitcnt != LAST_BIT);
    smp_rx = (state == ST_XFER) && tick && !sclk;
  end

  burst_shift #(.W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (ld_tx),
    .load_val  (ld_val),
    .shift_out (sh_tx),
    .sample    (smp_rx),
    .miso      (miso),
    .mosi      (mosi),
    .cap_word  (cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      bitcnt   <= '0;
      wcnt     <= '0;
      gcnt     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_idx   <= '0;
      done     <= 1'b0;
      ovr_cnt  <= '0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (start_edge && state != ST_IDLE && ovr_cnt != '1)
        ovr_cnt <= ovr_cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (start_edge) begin
            cs_n  <= 1'b0;
            wcnt  <= '0;
            state <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            sclk   <= 1'b0;
            bitcnt <= '0;
            state  <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
              if (bitcnt == LAST_BIT && wcnt != '0) begin
                rd_valid <= 1'b1;
                rd_data  <= cap_word;
                rd_idx   <= IW'(wcnt - 1'b1);
              end
            end else if (bitcnt == LAST_BIT) begin
              if (wcnt == LAST_WRD) begin
                state <= ST_TAIL;
              end else begin
                wcnt  <= wcnt + 1'b1;
                gcnt  <= 1'b0;
                state <= ST_GAP;
              end
            end else begin
              sclk   <= 1'b0;
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gcnt) begin
              sclk   <= 1'b0;
              bitcnt <= '0;
              state  <= ST_XFER;
            end else begin
              gcnt <= 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_reader_chk.sv
module burst_reader_chk #(
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             rd_valid,
  input logic             done,
  input logic [OVR_W-1:0] ovr_cnt
);
  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> sclk);

  // R3
  mosi_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $changed(mosi) |-> ($fell(sclk) || $fell(cs_n)));

  // R7
  cs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (sclk && $past(sclk)));

  // R9
  done_cs_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R11
  valid_cs_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !cs_n);

  // R10
  ovr_step_chk: assert property (@(posedge clk) disable iff (rst)
    $changed(ovr_cnt) |-> (ovr_cnt == OVR_W'($past(ovr_cnt) + 1'b1)));
endmodule

bind burst_reader burst_reader_chk #(.OVR_W(OVR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .rd_valid (rd_valid),
  .done     (done),
  .ovr_cnt  (ovr_cnt)
);

// File: tb/test_burst_reader.sv
module test_burst_reader;
  localparam int H  = 4;
  localparam int N  = 12;
  localparam int OW = 2;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_ready = 1'b0;
  logic miso = 1'b0;
  logic cs_n, sclk, mosi, rd_valid, done;
  logic [15:0] rd_data;
  logic [IW-1:0] rd_idx;
  logic [OW-1:0] ovr_cnt;

  always #2.5 clk = ~clk;

  burst_reader #(.SYS_FREQ_HZ(8_000_000), .HALF_DIV(H), .NWORDS(N),
                 .OVR_W(OW), .IW(IW)) i_burst_reader (
    .clk(clk), .rst(rst), .data_ready(data_ready), .miso(miso),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_idx(rd_idx), .done(done), .ovr_cnt(ovr_cnt)
  );

  logic [15:0] resp [N];

  // counters owned by the monitor
  int m_checks = 0, m_errs = 0, frames = 0;
  // counters owned by the main sequence
  int s_checks = 0, s_errs = 0;
  bit wd_fail = 1'b0;

  function automatic logic [15:0] slave_word(int w);
    if (w == 0) return 16'hA5C3;
    if (w <= N) return resp[w-1];
    return 16'h0000;
  endfunction

  // slave model and protocol monitor, sampled between edges
  int cyc = 0, cs_fall_c = 0, last_rise = 0, last_fall = 0, dr_c = 0;
  int rises = 0, nval = 0, exp_idx = 0, sw_bit = 0, sw_word = 0;
  bit lead_ok, per_ok, gap_ok, in_frame = 1'b0;
  logic p_sclk = 1'b1, p_cs = 1'b1, p_dr = 1'b0;
  logic [15:0] s_rx = '0, got_cmd = '0;

  task automatic mchk(bit ok, string tag, longint act, longint exp);
    m_checks++;
    if (!ok) begin
      m_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [15:0] sw;
    cyc++;
    if (!rst) begin
      if (data_ready && !p_dr && cs_n) dr_c = cyc;
      if (p_cs && !cs_n) begin
        mchk(cyc - dr_c <= 4, "R2 start latency", cyc - dr_c, 4);
        frames++; in_frame = 1'b1; cs_fall_c = cyc; rises = 0; nval = 0;
        exp_idx = 0; sw_bit = 0; sw_word = 0;
        lead_ok = 1'b1; per_ok = 1'b1; gap_ok = 1'b1;
      end
      if (cs_n && sclk !== p_sclk)
        mchk(1'b0, "R3 sclk moved with cs_n high", sclk, p_sclk);
      if (!cs_n && p_sclk && !sclk) begin
        if (rises == 0) lead_ok &= (cyc - cs_fall_c >= H);
        else if (rises % 16 == 0) gap_ok &= (cyc - last_rise == 3*H);
        else per_ok &= (cyc - last_rise == H);
        sw = slave_word(sw_word);
        miso <= sw[15 - sw_bit];
        last_fall = cyc;
      end
      if (!cs_n && !p_sclk && sclk) begin
        per_ok &= (cyc - last_fall == H);
        s_rx = {s_rx[14:0], mosi};
        rises++; last_rise = cyc; sw_bit++;
        if (sw_bit == 16) begin
          if (sw_word == 0) got_cmd = s_rx;
          sw_word++; sw_bit = 0;
        end
      end
      if (rd_valid) begin
        mchk(!cs_n, "R11 valid while cs_n high", cs_n, 0);
        mchk(rd_idx == IW'(exp_idx), "R5 word index", rd_idx, exp_idx);
        if (exp_idx < N)
          mchk(rd_data == resp[exp_idx], "R5 word data", rd_data, resp[exp_idx]);
        exp_idx++; nval++;
      end
      if (done) begin
        mchk(cs_n, "R9 done with cs_n low", cs_n, 1);
        mchk(nval == N, "R9 done before all words", nval, N);
      end
      if (!p_cs && cs_n && in_frame) begin
        in_frame = 1'b0;
        mchk(done, "R9 done at cs_n rise", done, 1);
        mchk(cyc - last_rise >= H, "R7 trailing cs time", cyc - last_rise, H);
        mchk(lead_ok, "R7 lead time", lead_ok, 1);
        mchk(got_cmd == 16'h3E00, "R4 request word", got_cmd, 16'h3E00);
        mchk(rises == 16*(N+1), "R5 total edges", rises, 16*(N+1));
        mchk(per_ok, "R6 half period", per_ok, 1);
        mchk(gap_ok, "R8 inter-word gap", gap_ok, 1);
        mchk(nval == N, "R5 word count", nval, N);
      end
    end
    p_sclk = sclk; p_cs = cs_n; p_dr = data_ready;
  end

  task automatic schk(bit ok, string tag, longint act, longint exp);
    s_checks++;
    if (!ok) begin
      s_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_dr(int w);
    @(negedge clk); #1 data_ready = 1'b1;
    cyc_wait(w);
    #1 data_ready = 1'b0;
  endtask

  task automatic wait_done(string tag);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    schk(1'b0, tag, 0, 1);
  endtask

  int exp_ovr = 0;

  task automatic run_burst(int n_ovr, string tag);
    int f0;
    f0 = frames;
    pulse_dr(1 + $urandom % 3);
    for (int k = 0; k < n_ovr; k++) begin
      cyc_wait(20 + $urandom % 700);
      pulse_dr(1 + $urandom % 3);
      if (exp_ovr < (1 << OW) - 1) exp_ovr++;
    end
    wait_done(tag);
    cyc_wait(3);
    schk(frames == f0 + 1, "R10 no restart", frames - f0, 1);
    schk(ovr_cnt == OW'(exp_ovr), "R10 overrun count", ovr_cnt, exp_ovr);
  endtask

  task automatic run_all();
    int f0;
    void'($urandom(32'd4711));
    cyc_wait(3);
    schk(cs_n && sclk && !rd_valid && !done && ovr_cnt == 0,
         "R1 reset outputs", {cs_n, sclk, rd_valid, done}, 4'b1100);
    #1 rst = 1'b0;
    cyc_wait(1);
    schk(cs_n && sclk && !rd_valid && !done && ovr_cnt == 0,
         "R1 first cycle after reset", {cs_n, sclk, rd_valid, done}, 4'b1100);
    cyc_wait(10);
    for (int b = 0; b < 9; b++) begin
      for (int j = 0; j < N; j++) begin
        case (b)
          0: resp[j] = 16'hFFFF;
          1: resp[j] = 16'h0000;
          2: resp[j] = j[0] ? 16'h7FFE : 16'h8001;
          default: resp[j] = 16'($urandom);
        endcase
      end
      run_burst((b >= 3) ? int'($urandom % 3) : 0, "R5 burst finished");
      cyc_wait($urandom % 25);
    end
    // level held high: exactly one transaction
    for (int j = 0; j < N; j++) resp[j] = 16'(j * 16'h1111 + 3);
    f0 = frames;
    @(negedge clk); #1 data_ready = 1'b1;
    wait_done("R2 level burst finished");
    cyc_wait(200);
    schk(frames == f0 + 1 && cs_n, "R2 level starts once", frames - f0, 1);
    #1 data_ready = 1'b0;
    schk(ovr_cnt == OW'(exp_ovr), "R10 level counts no overrun", ovr_cnt, exp_ovr);
    // immediate re-trigger after done
    run_burst(0, "R2 back-to-back burst finished");
    run_burst(3, "R10 saturating burst finished");
    cyc_wait(5);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd_fail = 1'b1;
      end
    join_any
    if (wd_fail) begin
      s_checks++; s_errs++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("CHECKS %0d ERRORS %0d", s_checks + m_checks, s_errs + m_errs);
    $finish;
  end
endmodule